// File: doc/BRIEF.md
# PHY Status-Change Interrupt Register

This block is one 16-bit management register of an Ethernet PHY. It watches three live status inputs (duplex, speed and link). When any of them changes, a sticky flag for that source is set, and a register read clears it. Per-source masks and a master mask decide whether the flags raise an active-low interrupt. Bit 0 of the register shows the same interrupt condition.

Two mode bits change what the transmit-LED and receive-LED pins carry. In interrupt mode the transmit pin carries the interrupt. In full-duplex LED mode it carries the duplex indication. In both modes the receive pin carries activity. With neither mode set, both pins pass their normal LED signals through. Full-duplex LED mode wins when both mode bits are set.

Software reaches the register through a plain address, write-data, write-enable and read-strobe port. Read data is combinational, so it shows the register contents during the strobe cycle. Any clear caused by the read takes effect at the following clock edge.

Top module: `phy_irq_reg`

## Requirements
- R1: The register answers at address 26 (0x1A), and every other address reads 0. After reset it reads 0x0F00: bits 11..8 are 1 and all other bits are 0.
- R2: A write to address 26 updates only bit 15 (duplex-LED mode), bit 14 (interrupt mode), bit 11 (duplex mask), bit 10 (speed mask), bit 9 (link mask) and bit 8 (master mask). Bits 13:12 and 7:4 always read 0. Writes do not change bits 3..0.
- R3: A change on stat_duplex, stat_speed or stat_link sets bit 3, bit 2 or bit 1 respectively, from the clock edge that first samples the new value. The bit stays 1 until it is read.
- R4: A read strobe at address 26 returns the current contents in that cycle and clears bits 3..1 at the next edge. A change that lands in the same cycle as the read leaves its flag set.
- R5: While bit 8 is 1, bit 0 reads 0 and no interrupt is produced, whatever the flags and per-source masks hold.
- R6: A per-source mask bit of 1 stops only that source's flag from raising the interrupt. The flag itself still latches.
- R7: Bit 0 is 1 exactly when bit 8 is 0 and at least one unmasked flag is set. With only bit 14 set, pin_tx_n equals the inverse of bit 0 and pin_rx_n equals act_n.
- R8: With bit 15 set (whether or not bit 14 is set), pin_tx_n equals the inverse of stat_duplex and pin_rx_n equals act_n. The flags and bit 0 keep updating as usual.
- R9: With bits 15 and 14 both 0, pin_tx_n equals tx_led_n and pin_rx_n equals rx_led_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe; clears flags when the address matches |
| reg_rdata | output | 16 | Read data, combinational |
| stat_duplex | input | 1 | Live duplex status |
| stat_speed | input | 1 | Live speed status |
| stat_link | input | 1 | Live link status |
| tx_led_n | input | 1 | Normal transmit LED, active low |
| rx_led_n | input | 1 | Normal receive LED, active low |
| act_n | input | 1 | Activity indication, active low |
| pin_tx_n | output | 1 | Transmit-LED pin after mode muxing |
| pin_rx_n | output | 1 | Receive-LED pin after mode muxing |

## Verification
The assertions are checked on every cycle. They cover:
- flags that persist while no read occurs;
- a read leaving behind only the changes of its own cycle;
- the master mask holding bit 0 low;
- zeros in the reserved fields;
- the transmit pin agreeing with bit 0 in interrupt mode;
- the transmit pin following duplex in duplex-LED mode.

Some behaviours can only be shown by the directed scenarios:
- the reset value;
- which bits a write can reach;
- the exact edge at which a status change first appears;
- a per-source mask blocking the interrupt while its flag still latches;
- the pass-through pins;
- the precedence when both mode bits are set.

// File: rtl/phy_irq_reg.sv
module phy_irq_reg #(
  parameter int AW = 5,
  parameter logic [AW-1:0] ADDR = AW'(26)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [15:0]   reg_wdata,
  input  logic          reg_rd,
  output logic [15:0]   reg_rdata,
  input  logic          stat_duplex,
  input  logic          stat_speed,
  input  logic          stat_link,
  input  logic          tx_led_n,
  input  logic          rx_led_n,
  input  logic          act_n,
  output logic          pin_tx_n,
  output logic          pin_rx_n
);
  logic       fdx_en, int_en, msk_all;
  logic [2:0] msk, flg, prev, cur, chg;
  logic       int_stat;

  wire hit    = (reg_addr == ADDR);
  wire rd_hit = hit & reg_rd;
  wire wr_hit = hit & reg_wr;

  assign cur = {stat_duplex, stat_speed, stat_link};
  assign chg = cur ^ prev;

  always_ff @(posedge clk) prev <= cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdx_en  <= 1'b0;
      int_en  <= 1'b0;
      msk     <= 3'b111;
      msk_all <= 1'b1;
      flg     <= 3'b000;
    end else begin
      if (wr_hit) begin
        fdx_en  <= reg_wdata[15];
        int_en  <= reg_wdata[14];
        msk     <= reg_wdata[11:9];
        msk_all <= reg_wdata[8];
      end
      flg <= (flg & {3{~rd_hit}}) | chg;
    end
  end

  assign int_stat  = ~msk_all & |(flg & ~msk);
  assign reg_rdata = hit ? {fdx_en, int_en, 2'b00, msk, msk_all, 4'b0000, flg, int_stat}
                         : 16'h0000;

  assign pin_tx_n = fdx_en ? ~stat_duplex : (int_en ? ~int_stat : tx_led_n);
  assign pin_rx_n = (fdx_en | int_en) ? act_n : rx_led_n;
endmodule

module phy_irq_reg_chk #(
  parameter int AW = 5,
  parameter logic [AW-1:0] ADDR = AW'(26)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic [15:0]   reg_rdata,
  input logic          rd_hit,
  input logic [2:0]    flg,
  input logic [2:0]    chg,
  input logic          stat_duplex,
  input logic          pin_tx_n
);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((flg & $past(flg)) == $past(flg)));

  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (flg == $past(chg)));

  p_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR && reg_rdata[8]) |-> !reg_rdata[0]);

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR) |-> (reg_rdata[13:12] == 2'b00 && reg_rdata[7:4] == 4'h0));

  p_irq_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR && reg_rdata[14] && !reg_rdata[15]) |-> (pin_tx_n != reg_rdata[0]));

  p_fdx_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR && reg_rdata[15]) |-> (pin_tx_n != stat_duplex));
endmodule

bind phy_irq_reg phy_irq_reg_chk #(.AW(AW), .ADDR(ADDR)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .rd_hit(rd_hit), .flg(flg), .chg(chg), .stat_duplex(stat_duplex),
  .pin_tx_n(pin_tx_n)
);

// File: tb/test_phy_irq_reg.sv
module test_phy_irq_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] reg_addr = 5'd26;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic stat_duplex = 1'b0, stat_speed = 1'b0, stat_link = 1'b1;
  logic tx_led_n = 1'b1, rx_led_n = 1'b0, act_n = 1'b1;
  logic pin_tx_n, pin_rx_n;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  phy_irq_reg i_phy_irq_reg (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge clk); reg_addr = 5'd26; reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic peek(output logic [15:0] v);
    @(negedge clk); reg_addr = 5'd26; reg_rd = 1'b0; #1 v = reg_rdata;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk); reg_addr = 5'd26; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    peek(v); check("R1 reset value", v, 16'h0F00);
    @(negedge clk); reg_addr = 5'd3; #1 check("R1 other address", reg_rdata, 16'h0);
    reg_addr = 5'd26;
  endtask

  task automatic t_write;
    logic [15:0] v;
    wr(16'hFFFF); peek(v); check("R2 write all ones", v, 16'hCF00);
    wr(16'h3AF5); peek(v); check("R2 write pattern", v, 16'h0A00);
    wr(16'h0F00);
  endtask

  task automatic t_change;
    logic [15:0] v;
    @(negedge clk); stat_link = ~stat_link; #1 check("R3 not before edge", reg_rdata, 16'h0F00);
    peek(v); check("R3 link flag", v, 16'h0F02);
    @(negedge clk); stat_duplex = ~stat_duplex;
    peek(v); check("R3 duplex flag", v, 16'h0F0A);
    repeat (3) peek(v); check("R3 flags stay", v, 16'h0F0A);
    rd(v); check("R4 read returns flags", v, 16'h0F0A);
    peek(v); check("R4 read cleared", v, 16'h0F00);
    @(negedge clk); stat_speed = ~stat_speed; reg_rd = 1'b1; #1 v = reg_rdata;
    check("R4 read in change cycle", v, 16'h0F00);
    @(negedge clk); reg_rd = 1'b0; #1 check("R4 change kept", reg_rdata, 16'h0F04);
    rd(v);
    @(negedge clk); stat_link = ~stat_link; reg_addr = 5'd7; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; peek(v); check("R4 other address no clear", v, 16'h0F02);
    rd(v);
  endtask

  task automatic t_masks;
    logic [15:0] v;
    wr(16'h4000); rd(v);
    @(negedge clk); stat_link = ~stat_link;
    peek(v); check("R7 unmasked flag raises bit0", v, 16'h4003);
    check("R7 intr pin low", {15'h0, pin_tx_n}, 16'h0);
    check("R7 rx carries act", {15'h0, pin_rx_n}, {15'h0, act_n});
    act_n = 1'b0; #1 check("R7 rx follows act", {15'h0, pin_rx_n}, 16'h0);
    wr(16'h4100); peek(v); check("R5 master mask", v, 16'h4102);
    check("R5 pin inactive", {15'h0, pin_tx_n}, 16'h1);
    rd(v); wr(16'h4200);
    @(negedge clk); stat_link = ~stat_link;
    peek(v); check("R6 masked flag latches", v, 16'h4202);
    check("R6 no interrupt", {15'h0, pin_tx_n}, 16'h1);
    @(negedge clk); stat_speed = ~stat_speed;
    peek(v); check("R7 speed unmasked", v, 16'h4207);
    check("R7 pin asserted", {15'h0, pin_tx_n}, 16'h0);
    rd(v); peek(v); check("R7 read deasserts", v, 16'h4200);
    check("R7 pin released", {15'h0, pin_tx_n}, 16'h1);
  endtask

  task automatic t_pins;
    logic [15:0] v;
    wr(16'h0000);
    @(negedge clk); tx_led_n = 1'b0; rx_led_n = 1'b1; act_n = 1'b0; #1
    check("R9 tx pass", {15'h0, pin_tx_n}, 16'h0);
    check("R9 rx pass", {15'h0, pin_rx_n}, 16'h1);
    wr(16'h8000); stat_duplex = 1'b1; #1
    check("R8 tx is ~duplex", {15'h0, pin_tx_n}, 16'h0);
    check("R8 rx is act", {15'h0, pin_rx_n}, 16'h0);
    rd(v);
    wr(16'hC000);
    @(negedge clk); stat_duplex = 1'b0;
    peek(v); check("R8 both set flags update", v, 16'hC009);
    check("R8 duplex overrides interrupt", {15'h0, pin_tx_n}, 16'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_write; t_change; t_masks; t_pins;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule